// File: doc/BRIEF.md
# Pixel-Clock Divider Search Engine

This block picks the divider triple for a programmable clock synthesizer so that its output lands as close as possible to a requested pixel clock. The synthesizer output is `f_ref × M / (N1 × 2^N2)`, with a fixed 14318.18 kHz reference. A host supplies the target frequency, the smallest post-divider exponent it allows, and the lower and upper limits of the oscillator (VCO) band, all in whole kHz. It then pulses `start`. The engine checks every legal (N2, N1) pair in turn, works out the rounded multiplier M for each pair, and discards pairs whose M or VCO frequency is out of bounds. It keeps the candidate with the smallest absolute output error.

All arithmetic is integer. The reference is held in units of 10 Hz, the rounded M comes from a small sequential divider, and error magnitudes are compared by cross-multiplication, so the scan loop needs no further division. When the scan ends, `done` pulses for one cycle. The engine then presents a success flag, the chosen M, N1 and N2, and the two register bytes a synthesizer expects. These values are held until the next accepted `start`.

Top module: `pllsrch_top`

## Requirements
- R1: `start` is accepted only in a cycle where both `busy` and `done` are low, and the inputs are sampled in that cycle. `busy` is high from the next cycle until the scan ends. `done` is then high for exactly one cycle with `busy` low. A `start` given while `busy` is high has no effect on the result.
- R2: Let req be the requested frequency. If req < floor(vmin / 8) or req > floor(vmax / 2^n2_floor), no scan is made, and `done` rises no later than the third falling clock edge after `start` was sampled, with `found` = 0.
- R3: The scan runs N2 from `n2_floor` up to 3 in the outer loop and N1 from 3 to 33 in the inner loop. For each pair, M = round(req × N1 × 2^N2 / 14318.18), with an exact half rounding up. A pair is dropped if M lies outside 3..129.
- R4: A candidate is eligible only if its VCO frequency 14318.18 × M / N1 (kHz) lies within [vmin, vmax], both ends included.
- R5: The reported triple has the smallest |req − 14318.18 × M / (N1 × 2^N2)| of all eligible candidates. A later candidate replaces the held one only when its error is strictly smaller, so on a tie the earlier candidate in scan order wins.
- R6: `found` is 1 only if some eligible candidate has an error strictly below req. Otherwise `found` is 0 and the outputs read M = 127, N1 = 18, N2 = 2.
- R7: `m_byte` equals M − 2. `n_byte` carries N1 − 2 in bits 4:0 and N2 in bits 6:5, with bit 7 at zero.
- R8: After `done`, the outputs `found`, `m_val`, `n1_val`, `n2_val`, `m_byte` and `n_byte` keep their values until the next accepted `start`.
- R9: After reset: `busy` = 0, `done` = 0, `found` = 0, M = 127, N1 = 18, N2 = 2, `m_byte` = 0x7D, `n_byte` = 0x50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search with the inputs below |
| req_khz | input | FREQ_W | Requested output frequency in kHz |
| vco_min_khz | input | FREQ_W | Lowest allowed VCO frequency in kHz |
| vco_max_khz | input | FREQ_W | Highest allowed VCO frequency in kHz |
| n2_floor | input | 2 | Smallest post-divider exponent allowed |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | A usable divider triple was found |
| m_val | output | 8 | Chosen feedback multiplier M |
| n1_val | output | 6 | Chosen input divider N1 |
| n2_val | output | 2 | Chosen post-divider exponent N2 |
| m_byte | output | 8 | Multiplier register byte |
| n_byte | output | 8 | Packed divider register byte |

## Verification
The bench builds the engine with the default FREQ_W of 20, so the whole request range up to the 250 MHz VCO ceiling fits in the inputs. With that width, every request of the sweep drives a full scan of up to 124 candidates. The sweep covers every post-divider floor, the default band and narrow or single-point VCO bands, so no-candidate outcomes occur. Both rejection edges are tested one kHz inside and one kHz outside. The bench compares each result against an integer model of the search written from the requirements.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

    // Reference clock 14318.18 kHz held in 10 Hz units
    localparam int unsigned REF_X100   = 1431818;
    localparam int          SCALE      = 100;
    localparam int          FREQ_W_DEF = 20;

    // Field widths
    localparam int M_W   = 8;
    localparam int N1_W  = 6;
    localparam int N2_W  = 2;
    localparam int DEN_W = 9;   // N1 << N2 reaches 264

    // Search bounds
    localparam int N1_LO  = 3;
    localparam int N1_HI  = 33;
    localparam int N2_TOP = 3;
    localparam int M_LO   = 3;
    localparam int M_HI   = 129;

    // Values reported when nothing beats the starting error
    localparam int M_DEF  = 127;
    localparam int N1_DEF = 18;
    localparam int N2_DEF = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_LAUNCH,
        ST_WAIT,
        ST_EVAL,
        ST_FINISH
    } state_e;

    typedef struct packed {
        logic [M_W-1:0]  m;
        logic [N1_W-1:0] n1;
        logic [N2_W-1:0] n2;
    } divset_t;

    function automatic divset_t default_set();
        divset_t s;
        s.m  = M_W'(M_DEF);
        s.n1 = N1_W'(N1_DEF);
        s.n2 = N2_W'(N2_DEF);
        return s;
    endfunction

    function automatic logic [7:0] m_reg_byte(input logic [M_W-1:0] m);
        return 8'(m - M_W'(2));
    endfunction

    function automatic logic [7:0] n_reg_byte(input logic [N1_W-1:0] n1,
                                              input logic [N2_W-1:0] n2);
        logic [N1_W-1:0] t;
        t = n1 - N1_W'(2);
        return {1'b0, n2, t[4:0]};
    endfunction

endpackage

// File: rtl/pllsrch_div.sv
// Sequential divider by 2*REF: one quotient bit per cycle, flags quotients >= 2^M_W
module pllsrch_div
    import pllsrch_pkg::*;
#(
    parameter int DIV_W = 38
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [DIV_W-1:0] dividend,
    output logic             ready,
    output logic [M_W-1:0]   quot,
    output logic             ovf
);
    localparam int               IDX_W   = $clog2(M_W);
    localparam logic [DIV_W-1:0] DVSR    = DIV_W'(2 * REF_X100);
    localparam logic [DIV_W-1:0] OVF_LIM = DVSR << M_W;

    logic [DIV_W-1:0] rem_q;
    logic [IDX_W-1:0] idx_q;
    logic             run_q;
    logic [DIV_W-1:0] step_d;
    logic             too_big;

    assign step_d  = DVSR << idx_q;
    assign too_big = (dividend >= OVF_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            idx_q <= '0;
            run_q <= 1'b0;
            ready <= 1'b0;
            quot  <= '0;
            ovf   <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (go) begin
                rem_q <= dividend;
                quot  <= '0;
                idx_q <= IDX_W'(M_W - 1);
                ovf   <= too_big;
                run_q <= !too_big;
                ready <= too_big;
            end else if (run_q) begin
                if (rem_q >= step_d) begin
                    rem_q       <= rem_q - step_d;
                    quot[idx_q] <= 1'b1;
                end
                if (idx_q == '0) begin
                    run_q <= 1'b0;
                    ready <= 1'b1;
                end else begin
                    idx_q <= idx_q - IDX_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pllsrch_eval.sv
// Combinational scoring of one candidate against the held best
module pllsrch_eval
    import pllsrch_pkg::*;
#(
    parameter int FREQ_W = FREQ_W_DEF,
    parameter int NUM_W  = FREQ_W + 16
) (
    input  logic [FREQ_W-1:0] req,
    input  logic [FREQ_W-1:0] vmin,
    input  logic [FREQ_W-1:0] vmax,
    input  logic [M_W-1:0]    m,
    input  logic [N1_W-1:0]   n1,
    input  logic [N2_W-1:0]   n2,
    input  logic              ovf,
    input  logic [NUM_W-1:0]  best_num,
    input  logic [DEN_W-1:0]  best_den,
    output logic [NUM_W-1:0]  num,
    output logic [DEN_W-1:0]  den,
    output logic [NUM_W-1:0]  err,
    output logic              take
);
    localparam int CMP_W = NUM_W + DEN_W;

    logic [NUM_W-1:0] prod;
    logic [NUM_W-1:0] vco_lo;
    logic [NUM_W-1:0] vco_hi;
    logic [CMP_W-1:0] lhs;
    logic [CMP_W-1:0] rhs;
    logic             m_ok;
    logic             vco_ok;

    always_comb begin
        den    = DEN_W'(n1) << n2;
        num    = NUM_W'(req) * NUM_W'(SCALE) * NUM_W'(den);
        prod   = NUM_W'(REF_X100) * NUM_W'(m);
        vco_lo = NUM_W'(vmin) * NUM_W'(SCALE) * NUM_W'(n1);
        vco_hi = NUM_W'(vmax) * NUM_W'(SCALE) * NUM_W'(n1);
        m_ok   = !ovf && (m >= M_W'(M_LO)) && (m <= M_W'(M_HI));
        vco_ok = (prod >= vco_lo) && (prod <= vco_hi);
        err    = (num >= prod) ? (num - prod) : (prod - num);
        lhs    = CMP_W'(err) * CMP_W'(best_den);
        rhs    = CMP_W'(best_num) * CMP_W'(den);
        take   = m_ok && vco_ok && (lhs < rhs);
    end

endmodule

// File: rtl/pllsrch_top.sv
module pllsrch_top
    import pllsrch_pkg::*;
#(
    parameter int FREQ_W = FREQ_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] req_khz,
    input  logic [FREQ_W-1:0] vco_min_khz,
    input  logic [FREQ_W-1:0] vco_max_khz,
    input  logic [N2_W-1:0]   n2_floor,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [M_W-1:0]    m_val,
    output logic [N1_W-1:0]   n1_val,
    output logic [N2_W-1:0]   n2_val,
    output logic [7:0]        m_byte,
    output logic [7:0]        n_byte
);
    localparam int NUM_W = FREQ_W + 16;
    localparam int DIV_W = NUM_W + 2;

    state_e            state_q;
    logic [FREQ_W-1:0] req_q;
    logic [FREQ_W-1:0] vmin_q;
    logic [FREQ_W-1:0] vmax_q;
    logic [N2_W-1:0]   floor_q;
    logic [N1_W-1:0]   n1_q;
    logic [N2_W-1:0]   n2_q;
    divset_t           best_q;
    logic [NUM_W-1:0]  best_num_q;
    logic [DEN_W-1:0]  best_den_q;
    logic              found_q;

    logic              reject;
    logic [FREQ_W-1:0] lo_lim;
    logic [FREQ_W-1:0] hi_lim;
    logic [NUM_W-1:0]  cand_num;
    logic [DEN_W-1:0]  cand_den;
    logic [NUM_W-1:0]  cand_err;
    logic              cand_take;
    logic [DIV_W-1:0]  dividend;
    logic              div_go;
    logic              div_ready;
    logic [M_W-1:0]    div_quot;
    logic              div_ovf;

    assign lo_lim   = vmin_q >> 3;
    assign hi_lim   = vmax_q >> floor_q;
    assign reject   = (req_q < lo_lim) || (req_q > hi_lim);
    assign dividend = (DIV_W'(cand_num) << 1) + DIV_W'(REF_X100);
    assign div_go   = (state_q == ST_LAUNCH);

    pllsrch_eval #(
        .FREQ_W (FREQ_W),
        .NUM_W  (NUM_W)
    ) u_eval (
        .req      (req_q),
        .vmin     (vmin_q),
        .vmax     (vmax_q),
        .m        (div_quot),
        .n1       (n1_q),
        .n2       (n2_q),
        .ovf      (div_ovf),
        .best_num (best_num_q),
        .best_den (best_den_q),
        .num      (cand_num),
        .den      (cand_den),
        .err      (cand_err),
        .take     (cand_take)
    );

    pllsrch_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (dividend),
        .ready    (div_ready),
        .quot     (div_quot),
        .ovf      (div_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            req_q      <= '0;
            vmin_q     <= '0;
            vmax_q     <= '0;
            floor_q    <= '0;
            n1_q       <= '0;
            n2_q       <= '0;
            best_q     <= default_set();
            best_num_q <= '0;
            best_den_q <= DEN_W'(1);
            found_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        req_q      <= req_khz;
                        vmin_q     <= vco_min_khz;
                        vmax_q     <= vco_max_khz;
                        floor_q    <= n2_floor;
                        best_q     <= default_set();
                        best_num_q <= NUM_W'(req_khz) * NUM_W'(SCALE);
                        best_den_q <= DEN_W'(1);
                        found_q    <= 1'b0;
                        state_q    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (reject) begin
                        state_q <= ST_FINISH;
                    end else begin
                        n2_q    <= floor_q;
                        n1_q    <= N1_W'(N1_LO);
                        state_q <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (div_ready) state_q <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (cand_take) begin
                        best_q.m   <= div_quot;
                        best_q.n1  <= n1_q;
                        best_q.n2  <= n2_q;
                        best_num_q <= cand_err;
                        best_den_q <= cand_den;
                        found_q    <= 1'b1;
                    end
                    if (n1_q == N1_W'(N1_HI)) begin
                        if (n2_q == N2_W'(N2_TOP)) begin
                            state_q <= ST_FINISH;
                        end else begin
                            n2_q    <= n2_q + N2_W'(1);
                            n1_q    <= N1_W'(N1_LO);
                            state_q <= ST_LAUNCH;
                        end
                    end else begin
                        n1_q    <= n1_q + N1_W'(1);
                        state_q <= ST_LAUNCH;
                    end
                end
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state_q != ST_IDLE) && (state_q != ST_FINISH);
    assign done   = (state_q == ST_FINISH);
    assign found  = found_q;
    assign m_val  = best_q.m;
    assign n1_val = best_q.n1;
    assign n2_val = best_q.n2;
    assign m_byte = m_reg_byte(best_q.m);
    assign n_byte = n_reg_byte(best_q.n1, best_q.n2);

endmodule

// File: rtl/pllsrch_chk.sv
module pllsrch_chk
    import pllsrch_pkg::*;
#(
    parameter int FREQ_W = FREQ_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              found,
    input logic [M_W-1:0]    m_val,
    input logic [N1_W-1:0]   n1_val,
    input logic [N2_W-1:0]   n2_val,
    input logic [N2_W-1:0]   floor_q,
    input logic [FREQ_W-1:0] vmin_q,
    input logic [FREQ_W-1:0] vmax_q
);
    localparam int W = FREQ_W + 24;

    logic [W-1:0] vco_p;
    logic [W-1:0] vco_l;
    logic [W-1:0] vco_h;

    always_comb begin
        vco_p = W'(REF_X100) * W'(m_val);
        vco_l = W'(vmin_q) * W'(SCALE) * W'(n1_val);
        vco_h = W'(vmax_q) * W'(SCALE) * W'(n1_val);
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                 // R1
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                 // R1
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> busy);                             // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable({found, m_val, n1_val, n2_val})); // R8
    AST_LEGAL_RANGE: assert property (@(posedge clk) disable iff (rst)
        (done && found) |-> (m_val >= M_W'(M_LO)) && (m_val <= M_W'(M_HI))
                         && (n1_val >= N1_W'(N1_LO)) && (n1_val <= N1_W'(N1_HI))); // R3
    AST_N2_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (done && found) |-> (n2_val >= floor_q));                        // R3
    AST_VCO_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (done && found) |-> (vco_p >= vco_l) && (vco_p <= vco_h));       // R4
    AST_FAIL_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        (done && !found) |-> (m_val == M_W'(M_DEF)) && (n1_val == N1_W'(N1_DEF))
                          && (n2_val == N2_W'(N2_DEF)));                 // R6

endmodule

bind pllsrch_top pllsrch_chk #(.FREQ_W(FREQ_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .found   (found),
    .m_val   (m_val),
    .n1_val  (n1_val),
    .n2_val  (n2_val),
    .floor_q (floor_q),
    .vmin_q  (vmin_q),
    .vmax_q  (vmax_q)
);

// File: tb/pllsrch_top_test.sv
`timescale 1ns/1ps
module pllsrch_top_test;
    localparam int     FW  = 20;
    localparam longint REF = 1431818;
    localparam int     WD  = 195000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [FW-1:0] req_khz = '0;
    logic [FW-1:0] vco_min_khz = '0;
    logic [FW-1:0] vco_max_khz = '0;
    logic [1:0]    n2_floor = '0;
    logic          busy, done, found;
    logic [7:0]    m_val;
    logic [5:0]    n1_val;
    logic [1:0]    n2_val;
    logic [7:0]    m_byte, n_byte;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    pllsrch_top #(.FREQ_W(FW)) uut (
        .clk(clk), .rst(rst), .start(start), .req_khz(req_khz),
        .vco_min_khz(vco_min_khz), .vco_max_khz(vco_max_khz), .n2_floor(n2_floor),
        .busy(busy), .done(done), .found(found), .m_val(m_val), .n1_val(n1_val),
        .n2_val(n2_val), .m_byte(m_byte), .n_byte(n_byte)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Integer model of the search written from R2..R6
    function automatic void model(input longint req, input int mn, input longint vlo,
                                  input longint vhi, output bit f, output longint bm,
                                  output longint bn1, output longint bn2);
        longint bnum, bden;
        bnum = req * 100; bden = 1; f = 0; bm = 127; bn1 = 18; bn2 = 2;
        if (req < (vlo >> 3) || req > (vhi >> mn)) return;
        for (int n2 = mn; n2 <= 3; n2++) begin
            for (int n1 = 3; n1 <= 33; n1++) begin
                longint d, num, m, p, e;
                d   = longint'(n1) << n2;
                num = req * 100 * d;
                m   = (2 * num + REF) / (2 * REF);
                p   = REF * m;
                e   = (num > p) ? num - p : p - num;
                if (m >= 3 && m <= 129 && p >= vlo * 100 * n1 && p <= vhi * 100 * n1
                    && e * bden < bnum * d) begin
                    bnum = e; bden = d; bm = m; bn1 = n1; bn2 = n2; f = 1;
                end
            end
        end
    endfunction

    task automatic run(input longint req, input int mn, input longint vlo,
                       input longint vhi, input string tag, input bit poke);
        bit     ef;
        longint em, en1, en2;
        int     cyc;
        model(req, mn, vlo, vhi, ef, em, en1, en2);
        @(negedge clk);
        req_khz = FW'(req); n2_floor = 2'(mn);
        vco_min_khz = FW'(vlo); vco_max_khz = FW'(vhi);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 3000) begin
            if (poke && cyc == 20) begin
                // R1: a start with other inputs while busy must be ignored
                req_khz = FW'(req + 7777); n2_floor = 2'd3; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done == 1'b1, "R1", "done reached", done, 1);
        chk(busy == 1'b0, "R1", "busy low at done", busy, 0);
        if (tag == "R2") chk(ef || cyc <= 3, "R2", "reject latency", cyc, 3);
        chk(found == ef, ef ? tag : "R6", "found", found, ef);
        chk(m_val == em && n1_val == en1 && n2_val == en2, tag, "m/n1/n2",
            {m_val, n1_val, n2_val}, {em[7:0], en1[5:0], en2[1:0]});
        chk(m_byte == 8'(em - 2), "R7", "m_byte", m_byte, 8'(em - 2));
        chk(n_byte == 8'((en1 - 2) | (en2 << 5)), "R7", "n_byte", n_byte,
            8'((en1 - 2) | (en2 << 5)));
        @(negedge clk);
        chk(done == 1'b0, "R1", "done one cycle", done, 0);
        req_khz = FW'(req + 1234); n2_floor = 2'd1;
        repeat (4) @(negedge clk);
        chk(found == ef && m_val == em && n1_val == en1 && n2_val == en2, "R8",
            "held outputs", {found, m_val, n1_val, n2_val},
            {ef, em[7:0], en1[5:0], en2[1:0]});
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        tests++; fails++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(busy == 0 && done == 0 && found == 0, "R9", "flags", {busy, done, found}, 0);
        chk(m_val == 127 && n1_val == 18 && n2_val == 2, "R9", "triple",
            {m_val, n1_val, n2_val}, {8'd127, 6'd18, 2'd2});
        chk(m_byte == 8'h7D && n_byte == 8'h50, "R9", "bytes", {m_byte, n_byte}, 16'h7D50);

        // R2 rejection edges
        run(12499, 0, 100000, 250000, "R2", 0);
        run(12500, 0, 100000, 250000, "R2", 0);
        run(250001, 0, 100000, 250000, "R2", 0);
        run(250000, 0, 100000, 250000, "R2", 0);
        run(62501, 2, 100000, 250000, "R2", 0);
        run(62500, 2, 100000, 250000, "R2", 0);
        run(31251, 3, 100000, 250000, "R2", 0);
        run(0, 0, 100000, 250000, "R2", 0);

        // R1 start while busy
        run(25175, 0, 100000, 250000, "R1", 1);

        // R5 sweep over the default band, floor 0
        for (int i = 0; i < 32; i++)
            run(12600 + i * 7400 + (i * 37) % 1000, 0, 100000, 250000, "R5", 0);

        // R3 other floors
        for (int k = 1; k <= 3; k++)
            for (int i = 0; i < 10; i++)
                run(12600 + i * ((250000 >> k) - 12600) / 10 + i * 13, k,
                    100000, 250000, "R3", 0);

        // R4 narrow and single-point VCO bands
        run(40000, 0, 150000, 160000, "R4", 0);
        run(75000, 1, 150000, 160000, "R4", 0);
        run(50000, 0, 200000, 200000, "R4", 0);
        run(31500, 0, 120000, 130000, "R4", 0);
        run(65000, 0, 240000, 250000, "R4", 0);
        run(108000, 0, 215000, 217000, "R4", 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule